// File: doc/BRIEF.md
# Serial Word Assembler with Label Filter

This block sits behind a line sampler that has already decided, bit by bit, what the receive line carried. Each validated data bit arrives with a one-cycle strobe, and a separate strobe marks a confirmed inter-word null. The block builds these bits into a 32-bit word and counts them to find the end of the word. It checks that the word has odd parity. It also requires a gap between words and flags any break in that rule.

A complete word with good parity is then screened by its 8-bit label, which is the first eight bits received. The label must match a valid entry of a 16-entry table, or filtering must be switched off. Words that pass go into a four-word queue, and a host drains that queue through a simple show-ahead read port. The table is written one entry at a time through a small write port.

Top module: `serial_word_assembler`

## Requirements
- R1: After reset `rdy`, `par_err`, `seq_err` and `ovfl` are 0, the queue is empty, all table entries are invalid, and the receiver is ready to start a word without first seeing a gap.
- R2: Bits are shifted in on `bit_stb`. The first bit received lands in bit 0 of the stored word and the 32nd in bit 31, so the label occupies bits 7:0.
- R3: A completed word whose 32 bits have even parity is discarded, and `par_err` pulses high for exactly one cycle.
- R4: With `filt_en`=1, a good-parity word is stored only if bits 7:0 equal the label of a table entry whose valid bit is 1.
- R5: With `filt_en`=0, every good-parity word is stored whatever its label.
- R6: A `gap_stb` that arrives while a word is partly received discards the partial word and pulses `seq_err` for one cycle. The next word then assembles from bit 0.
- R7: A `bit_stb` that arrives after a completed word and before any `gap_stb` is ignored and pulses `seq_err`. If `gap_stb` and `bit_stb` come in the same cycle, the gap wins.
- R8: The queue holds 4 words and returns them in arrival order on `rd_data`. `rdy` is high while it is not empty, and `rd_en` removes the head word.
- R9: An accepted word that arrives while the queue holds 4 words is dropped, and `ovfl` goes high and stays high until reset.
- R10: A pulse on `tbl_we` writes `tbl_label` and `tbl_valid` into entry `tbl_idx`. Clearing the valid bit stops that entry from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle strobe: a validated data bit is present |
| bit_val | input | 1 | Value of the strobed bit |
| gap_stb | input | 1 | One-cycle strobe: a valid word gap was detected |
| filt_en | input | 1 | 1 enables label filtering |
| tbl_we | input | 1 | Label table write enable |
| tbl_idx | input | 4 | Table entry to write |
| tbl_label | input | 8 | Label value to write |
| tbl_valid | input | 1 | Valid bit to write |
| rd_en | input | 1 | Remove the head word from the queue |
| rd_data | output | 32 | Head word of the queue (show-ahead) |
| rdy | output | 1 | Queue not empty |
| par_err | output | 1 | One-cycle parity error pulse |
| seq_err | output | 1 | One-cycle sequence or gap error pulse |
| ovfl | output | 1 | Sticky queue overflow flag |

## Verification
A bit counter that drifts shows up at the next word. That word is either split, so a word appears one word early or not at all, or its bits come out rotated on `rd_data`. Either way it is visible as soon as the word is read. A lost or stuck gap flag shows as a missing or extra `seq_err` pulse on the very first bit after a word. A wrong queue pointer or count shows up when the bench drains the queue: words come back out of order or repeated, or `rdy` falls at the wrong pop.

// File: rtl/swa_pkg.sv
package swa_pkg;
    localparam int WORD_W = 32;
    localparam int LBL_W  = 8;

    typedef struct packed {
        logic [LBL_W-1:0] label;
        logic             valid;
    } tbl_entry_t;
endpackage

// File: rtl/swa_label_table.sv
module swa_label_table
    import swa_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(N_ENT)-1:0] widx,
    input  logic [LBL_W-1:0]         wlabel,
    input  logic                     wvalid,
    input  logic [LBL_W-1:0]         look_label,
    output logic                     hit
);
    tbl_entry_t          ent_q [N_ENT];
    tbl_entry_t          ent_d [N_ENT];
    logic [N_ENT-1:0]    match;

    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (we) begin
            ent_d[widx] = '{label: wlabel, valid: wvalid};
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENT; i++) begin
            if (!rst_n) ent_q[i] <= '0;
            else        ent_q[i] <= ent_d[i];
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign match[g] = ent_q[g].valid && (ent_q[g].label == look_label);
    end

    assign hit = |match;

    // R10: a write lands in the addressed entry
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ent_q[$past(widx)].label == $past(wlabel)) &&
               (ent_q[$past(widx)].valid == $past(wvalid)));
endmodule

// File: rtl/swa_fifo.sv
module swa_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         not_empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t         ctl_q, ctl_d;
    logic [W-1:0] mem_q [DEPTH];
    logic         do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (ctl_q.cnt == CNT_W'(DEPTH));
    assign not_empty = (ctl_q.cnt != '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;
    assign rdata     = mem_q[ctl_q.rptr];

    always_comb begin
        ctl_d = ctl_q;
        if (do_push) ctl_d.wptr = bump(ctl_q.wptr);
        if (do_pop)  ctl_d.rptr = bump(ctl_q.rptr);
        case ({do_push, do_pop})
            2'b10:   ctl_d.cnt = ctl_q.cnt + 1'b1;
            2'b01:   ctl_d.cnt = ctl_q.cnt - 1'b1;
            default: ctl_d.cnt = ctl_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[ctl_q.wptr] <= wdata;
    end

    // R8: occupancy never exceeds the depth
    a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cnt <= CNT_W'(DEPTH));
    // R8: the queue only empties through a read
    a_r8_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
        (not_empty && !pop) |=> not_empty);
endmodule

// File: rtl/serial_word_assembler.sv
module serial_word_assembler
    import swa_pkg::*;
#(
    parameter int N_ENT   = 16,
    parameter int Q_DEPTH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_stb,
    input  logic                     bit_val,
    input  logic                     gap_stb,
    input  logic                     filt_en,
    input  logic                     tbl_we,
    input  logic [$clog2(N_ENT)-1:0] tbl_idx,
    input  logic [LBL_W-1:0]         tbl_label,
    input  logic                     tbl_valid,
    input  logic                     rd_en,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     rdy,
    output logic                     par_err,
    output logic                     seq_err,
    output logic                     ovfl
);
    localparam int CNT_W = $clog2(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
        logic              armed;
        logic              par_err;
        logic              seq_err;
        logic              ovfl;
    } asm_t;

    asm_t              st_q, st_d;
    logic [WORD_W-1:0] shifted;
    logic              lbl_hit;
    logic              q_full;
    logic              push;

    assign shifted = {bit_val, st_q.word[WORD_W-1:1]};

    swa_label_table #(.N_ENT(N_ENT)) i_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (tbl_we),
        .widx       (tbl_idx),
        .wlabel     (tbl_label),
        .wvalid     (tbl_valid),
        .look_label (shifted[LBL_W-1:0]),
        .hit        (lbl_hit)
    );

    swa_fifo #(.W(WORD_W), .DEPTH(Q_DEPTH)) i_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .wdata     (shifted),
        .pop       (rd_en),
        .rdata     (rd_data),
        .full      (q_full),
        .not_empty (rdy)
    );

    always_comb begin
        st_d         = st_q;
        st_d.par_err = 1'b0;
        st_d.seq_err = 1'b0;
        push         = 1'b0;
        if (gap_stb) begin
            if (st_q.cnt != '0) st_d.seq_err = 1'b1;
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else if (bit_stb) begin
            if (!st_q.armed) begin
                st_d.seq_err = 1'b1;
            end else begin
                st_d.word = shifted;
                if (st_q.cnt == CNT_W'(WORD_W - 1)) begin
                    st_d.cnt   = '0;
                    st_d.armed = 1'b0;
                    if (^shifted) begin
                        if (!filt_en || lbl_hit) begin
                            if (q_full) st_d.ovfl = 1'b1;
                            else        push      = 1'b1;
                        end
                    end else begin
                        st_d.par_err = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign par_err = st_q.par_err;
    assign seq_err = st_q.seq_err;
    assign ovfl    = st_q.ovfl;

    // R9: overflow flag is sticky
    a_r9_ovfl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovfl |=> ovfl);
    // R7: a bit with no preceding gap raises a sequence error
    a_r7_unarmed_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && !gap_stb && !st_q.armed) |=> seq_err);
    // R3: error pulses never coincide
    a_r3_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_err && seq_err));
    // R3: a parity error never follows a store
    a_r3_no_store_on_perr: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !par_err);
endmodule

// File: tb/test_serial_word_assembler.sv
module test_serial_word_assembler;
    localparam int PERIOD = 10;

    // {label[7:0], payload[22:0], good_parity, expect_stored}
    localparam logic [32:0] VEC [6] = '{
        {8'hA5, 23'h012345, 1'b1, 1'b1},
        {8'h3C, 23'h7FFFFF, 1'b1, 1'b1},
        {8'h77, 23'h000ABC, 1'b1, 1'b0},
        {8'hA5, 23'h055555, 1'b0, 1'b0},
        {8'h11, 23'h0F0F0F, 1'b1, 1'b0},
        {8'h3C, 23'h000000, 1'b1, 1'b1}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bit_stb = 0, bit_val = 0, gap_stb = 0, filt_en = 1;
    logic        tbl_we = 0, tbl_valid = 0, rd_en = 0;
    logic [3:0]  tbl_idx = 0;
    logic [7:0]  tbl_label = 0;
    logic [31:0] rd_data;
    logic        rdy, par_err, seq_err, ovfl;

    int n_chk = 0, n_fail = 0;
    int perr_n = 0, serr_n = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    serial_word_assembler i_serial_word_assembler (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .gap_stb(gap_stb), .filt_en(filt_en), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_label(tbl_label), .tbl_valid(tbl_valid),
        .rd_en(rd_en), .rd_data(rd_data), .rdy(rdy), .par_err(par_err),
        .seq_err(seq_err), .ovfl(ovfl)
    );

    always @(negedge clk) begin
        if (par_err) perr_n++;
        if (seq_err) serr_n++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_stb = 1; bit_val = b;
        @(negedge clk); bit_stb = 0;
    endtask

    task automatic send_gap();
        @(negedge clk); gap_stb = 1;
        @(negedge clk); gap_stb = 0;
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 0; i < 32; i++) send_bit(w[i]);
        idle(2);
    endtask

    task automatic pop();
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wr_tbl(input logic [3:0] idx, input logic [7:0] lbl, input logic v);
        @(negedge clk); tbl_we = 1; tbl_idx = idx; tbl_label = lbl; tbl_valid = v;
        @(negedge clk); tbl_we = 0;
    endtask

    function automatic logic [31:0] mk(input logic [7:0] lbl, input logic [22:0] pay, input logic good);
        logic x;
        x = ^{pay, lbl};
        return {good ? ~x : x, pay, lbl};
    endfunction

    initial begin
        #(PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        if (!done) $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [31:0] ov [5];
        int p0, s0;
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset state
        check(!rdy && !par_err && !seq_err && !ovfl, "R1",
              {28'd0, rdy, par_err, seq_err, ovfl}, 32'd0);

        wr_tbl(4'd0, 8'hA5, 1);
        wr_tbl(4'd3, 8'h3C, 1);
        wr_tbl(4'd5, 8'h77, 0);

        // Table walk: R2, R3, R4
        for (int v = 0; v < 6; v++) begin
            w  = mk(VEC[v][32:25], VEC[v][24:2], VEC[v][1]);
            p0 = perr_n;
            send_gap();
            send_word(w);
            check((perr_n - p0) == (VEC[v][1] ? 0 : 1), "R3 parity pulse",
                  perr_n - p0, VEC[v][1] ? 0 : 1);
            check(rdy == VEC[v][0], "R4 label filter", rdy, VEC[v][0]);
            if (VEC[v][0]) begin
                check(rd_data == w, "R2 word order", rd_data, w);
                pop();
            end
        end

        // R5: filter off stores unknown label
        filt_en = 0;
        w = mk(8'h11, 23'h123456, 1);
        send_gap(); send_word(w);
        check(rdy && rd_data == w, "R5 filter bypass", rd_data, w);
        pop();
        filt_en = 1;

        // R6: gap mid-word aborts
        s0 = serr_n;
        send_gap();
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        send_gap();
        idle(1);
        check(serr_n - s0 == 1, "R6 abort pulse", serr_n - s0, 1);
        w = mk(8'hA5, 23'h2AAAAA, 1);
        send_word(w);
        check(rdy && rd_data == w, "R6 restart at bit 0", rd_data, w);
        pop();

        // R7: bit after word without gap
        s0 = serr_n;
        send_bit(1'b1);
        idle(1);
        check(serr_n - s0 == 1, "R7 missing gap", serr_n - s0, 1);
        check(!rdy, "R7 bit ignored", rdy, 0);
        send_gap();
        w = mk(8'h3C, 23'h00FFFF, 1);
        send_word(w);
        check(rdy && rd_data == w, "R7 next word clean", rd_data, w);
        pop();

        // R10: clearing entry 0 stops A5 matching
        wr_tbl(4'd0, 8'hA5, 0);
        send_gap(); send_word(mk(8'hA5, 23'h000001, 1));
        check(!rdy, "R10 invalidated entry", rdy, 0);

        // R8, R9: fill queue past depth
        filt_en = 0;
        for (int k = 0; k < 5; k++) begin
            ov[k] = mk(8'(k + 1), 23'(k * 77), 1);
            send_gap(); send_word(ov[k]);
            if (k == 3) check(!ovfl, "R9 no overflow at 4", ovfl, 0);
        end
        check(ovfl, "R9 overflow set", ovfl, 1);
        for (int k = 0; k < 4; k++) begin
            check(rdy && rd_data == ov[k], "R8 fifo order", rd_data, ov[k]);
            pop();
        end
        check(!rdy, "R8 empty after 4 reads", rdy, 0);
        check(ovfl, "R9 overflow sticky", ovfl, 1);

        // R7: gap wins over simultaneous bit
        s0 = serr_n;
        @(negedge clk); gap_stb = 1; bit_stb = 1; bit_val = 1;
        @(negedge clk); gap_stb = 0; bit_stb = 0;
        w = mk(8'h42, 23'h654321, 1);
        send_word(w);
        check(rdy && rd_data == w && serr_n == s0, "R7 gap priority", rd_data, w);
        pop();

        // R1: reset clears overflow and queue
        rst_n = 0; idle(2); rst_n = 1; idle(1);
        check(!ovfl && !rdy, "R1 reset clears", {30'd0, ovfl, rdy}, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule